// File: doc/BRIEF.md
# Bayer Quad to RGB Half-Resolution Converter

This block turns a raw camera stream of 10-bit Bayer samples into a packed RGB stream at half the resolution in each axis. Every 2x2 colour quad of the sensor becomes exactly one output pixel. The red and blue come straight from the quad's single red and single blue samples. The green is the mean of the quad's two green samples. A full 1280x960 sensor frame therefore yields a 640x480 image.

The first line of each line pair (the top line) is held in an internal buffer of one entry per quad. While the second line (the bottom line) arrives, each completed quad is merged with its stored top half. The result is placed in a single output register that feeds a 32-bit FIFO. The camera cannot be stalled, so a FIFO that is not ready makes the block hold its current word and discard new ones until the word is taken.

Top module: `bayerQuadDownscaler`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `outValid` is 0 and `outData` is 0.
- R2: A sample counts only when `pixValid`, `lineValid` and `frameValid` are all high. Line parity starts even and toggles at every falling edge of `lineValid`. Even lines produce no output. On an odd line, the second sample of each column pair produces one word, and `outValid` rises in the cycle after that sample's clock edge.
- R3: With the default phase (GRBG: green then red on even lines, blue then green on odd lines), red is bits [9:2] of the even-line odd-column sample and blue is bits [9:2] of the odd-line even-column sample.
- R4: Green is bits [10:3] of the 11-bit sum of the two green samples, for example 1023+1022 gives 255 and 1+6 gives 0.
- R5: The word layout is {8'h00, red, green, blue}, so bits [31:24] are always zero.
- R6: Cycles with `pixValid` low inside a line are ignored: they neither advance the column nor alter the result, whatever is on `pixData`.
- R7: Whenever `frameValid` is low, line parity returns to even, so each frame's first line is a top line even if the previous frame ended mid-pair.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` is unchanged.
- R9: A word that completes while the output register holds a word that is not being taken in that cycle is discarded.
- R10: When a word completes in the same cycle that the held word is taken, the new word is loaded with no idle cycle between them.
- R11: The `PHASE` parameter selects the colour order. With RGGB, red is the even-line even-column sample, blue is the odd-line odd-column sample, and the other two samples are green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixData | input | 10 | Raw Bayer sample |
| pixValid | input | 1 | Sample strobe |
| lineValid | input | 1 | High during the active part of a line |
| frameValid | input | 1 | High during the active part of a frame |
| outData | output | 32 | Packed RGB word {0, R, G, B} |
| outValid | output | 1 | Word present in the output register |
| outReady | input | 1 | Downstream FIFO can accept a word |

## Verification
Two functions can fall in the same clock edge: a bottom-line quad completing, and the FIFO taking the word already held. The bench holds `outReady` low so that quad 0 fills the register and quad 1 is discarded. It then raises `outReady` in the very cycle whose edge completes quad 2. Correct behaviour shows quad 2's word in the following cycle with `outValid` still high. It must not show quad 0 again, a lost quad 2, or a cycle with `outValid` low.

// File: rtl/bayerQuadPkg.sv
package bayerQuadPkg;
  typedef enum logic [1:0] {PH_GRBG, PH_RGGB, PH_BGGR, PH_GBRG} phase_e;

  typedef struct packed {
    logic holdFirst;
    logic storeTop;
    logic emitQuad;
  } ctlStrobe_t;
endpackage

// File: rtl/bqControl.sv
module bqControl
  import bayerQuadPkg::*;
#(
  parameter int LINE_W = 1280,
  localparam int QUADS = LINE_W / 2,
  localparam int COL_W = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             lineValid,
  input  logic             frameValid,
  output ctlStrobe_t       strobe,
  output logic [COL_W-1:0] colIdx
);
  logic xOdd;
  logic oddLine;
  logic lineValidD;
  logic accept;

  assign accept = pixValid & lineValid & frameValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xOdd       <= 1'b0;
      oddLine    <= 1'b0;
      lineValidD <= 1'b0;
      colIdx     <= '0;
    end else begin
      lineValidD <= lineValid;
      if (!frameValid) oddLine <= 1'b0;
      else if (lineValidD && !lineValid) oddLine <= ~oddLine;
      if (!lineValid) begin
        xOdd   <= 1'b0;
        colIdx <= '0;
      end else if (accept) begin
        xOdd <= ~xOdd;
        if (xOdd) colIdx <= (colIdx == COL_W'(QUADS - 1)) ? '0 : colIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.holdFirst = accept & ~xOdd;
    strobe.storeTop  = accept & xOdd & ~oddLine;
    strobe.emitQuad  = accept & xOdd & oddLine;
  end
endmodule

// File: rtl/bqDatapath.sv
module bqDatapath
  import bayerQuadPkg::*;
#(
  parameter int     LINE_W = 1280,
  parameter int     PIX_W  = 10,
  parameter phase_e PHASE  = PH_GRBG,
  localparam int QUADS = LINE_W / 2,
  localparam int COL_W = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixData,
  input  ctlStrobe_t       strobe,
  input  logic [COL_W-1:0] colIdx,
  input  logic             outReady,
  output logic [31:0]      outData,
  output logic             outValid
);
  logic [PIX_W-1:0]   firstPix;
  logic [2*PIX_W-1:0] topMem [QUADS];
  logic [2*PIX_W-1:0] topWord;
  logic [PIX_W-1:0]   sA, sB, sC, sD;
  logic [PIX_W-1:0]   rRaw, bRaw, g1, g2;
  logic [PIX_W:0]     gSum;
  logic [31:0]        word;

  always_ff @(posedge clk) begin
    if (!rstN) firstPix <= '0;
    else if (strobe.holdFirst) firstPix <= pixData;
  end

  always_ff @(posedge clk) begin
    if (strobe.storeTop) topMem[colIdx] <= {firstPix, pixData};
  end

  assign topWord = topMem[colIdx];
  assign sA = topWord[2*PIX_W-1:PIX_W];
  assign sB = topWord[PIX_W-1:0];
  assign sC = firstPix;
  assign sD = pixData;

  generate
    if (PHASE == PH_GRBG) begin : gPhase
      assign rRaw = sB; assign bRaw = sC; assign g1 = sA; assign g2 = sD;
    end else if (PHASE == PH_RGGB) begin : gPhase
      assign rRaw = sA; assign bRaw = sD; assign g1 = sB; assign g2 = sC;
    end else if (PHASE == PH_BGGR) begin : gPhase
      assign rRaw = sD; assign bRaw = sA; assign g1 = sB; assign g2 = sC;
    end else begin : gPhase
      assign rRaw = sC; assign bRaw = sB; assign g1 = sA; assign g2 = sD;
    end
  endgenerate

  assign gSum = {1'b0, g1} + {1'b0, g2};
  assign word = {8'h00, rRaw[PIX_W-1 -: 8], gSum[PIX_W -: 8], bRaw[PIX_W-1 -: 8]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strobe.emitQuad && (!outValid || outReady)) begin
      outValid <= 1'b1;
      outData  <= word;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/bayerQuadDownscaler.sv
module bayerQuadDownscaler
  import bayerQuadPkg::*;
#(
  parameter int     LINE_W = 1280,
  parameter int     PIX_W  = 10,
  parameter phase_e PHASE  = PH_GRBG,
  localparam int QUADS = LINE_W / 2,
  localparam int COL_W = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixData,
  input  logic             pixValid,
  input  logic             lineValid,
  input  logic             frameValid,
  output logic [31:0]      outData,
  output logic             outValid,
  input  logic             outReady
);
  ctlStrobe_t       strobe;
  logic [COL_W-1:0] colIdx;

  bqControl #(.LINE_W(LINE_W)) uCtl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineValid(lineValid),
    .frameValid(frameValid), .strobe(strobe), .colIdx(colIdx)
  );

  bqDatapath #(.LINE_W(LINE_W), .PIX_W(PIX_W), .PHASE(PHASE)) uDp (
    .clk(clk), .rstN(rstN), .pixData(pixData), .strobe(strobe), .colIdx(colIdx),
    .outReady(outReady), .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/bqChecker.sv
module bqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        pixValid,
  input logic        lineValid,
  input logic        frameValid,
  input logic        outReady,
  input logic        outValid,
  input logic [31:0] outData
);
  AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outData[31:24] == 8'h00); // R5

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R8

  AST_NO_WORD_WITHOUT_PIXEL: assert property (@(posedge clk) disable iff (!rstN)
    outReady && !(pixValid && lineValid && frameValid) |=> !outValid); // R6

  AST_RISE_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(pixValid && lineValid && frameValid)); // R2
endmodule

bind bayerQuadDownscaler bqChecker uChk (.*);

// File: tb/sim_bayerQuadDownscaler.sv
module sim_bayerQuadDownscaler;
  import bayerQuadPkg::*;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] pixData = '0;
  logic pixValid = 1'b0, lineValid = 1'b0, frameValid = 1'b0, outReady = 1'b1;
  logic [31:0] outData, outData1;
  logic outValid, outValid1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bayerQuadDownscaler #(.LINE_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixValid(pixValid), .lineValid(lineValid),
    .frameValid(frameValid), .outData(outData), .outValid(outValid), .outReady(outReady));

  bayerQuadDownscaler #(.LINE_W(LW), .PHASE(PH_RGGB)) u1 (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixValid(pixValid), .lineValid(lineValid),
    .frameValid(frameValid), .outData(outData1), .outValid(outValid1), .outReady(outReady));

  function automatic int pv(int seed, int line, int col);
    if (seed == 99) return (line % 2 == 0) ? ((col % 2 == 0) ? 1023 : 4) : ((col % 2 == 0) ? 8 : 1022);
    if (seed == 98) return (line % 2 == 0) ? ((col % 2 == 0) ? 1 : 1020) : ((col % 2 == 0) ? 1020 : 6);
    return (seed * 97 + line * 131 + col * 29 + col * col) % 1024;
  endfunction

  function automatic logic [31:0] expWord(bit rggb, int a, int b, int c, int d);
    int r, g, bl;
    if (!rggb) begin r = b; bl = c; g = (a + d) >> 3; end
    else begin r = a; bl = d; g = (b + c) >> 3; end
    return {8'h00, 8'(r >> 2), 8'(g), 8'(bl >> 2)};
  endfunction

  function automatic logic [31:0] quadWord(bit rggb, int seed, int line, int q);
    return expWord(rggb, pv(seed, line - 1, 2 * q), pv(seed, line - 1, 2 * q + 1),
                   pv(seed, line, 2 * q), pv(seed, line, 2 * q + 1));
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drivePix(int v);
    pixValid = 1'b1; pixData = 10'(v);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    pixValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendLine(int seed, int line, bit gap);
    lineValid = 1'b1;
    for (int col = 0; col < LW; col++) begin
      drivePix(pv(seed, line, col));
      if (col % 2 == 1) begin
        if (line % 2 == 1) begin
          logic [31:0] e0, e1;
          e0 = quadWord(0, seed, line, col / 2);
          e1 = quadWord(1, seed, line, col / 2);
          check(outValid === 1'b1, "R2 word valid", 32'(outValid), 32'd1);
          check(outData === e0, (seed >= 98) ? "R4 green mean" : "R3 colour", outData, e0);
          check(outData[31:24] === 8'h00, "R5 top byte", outData, e0);
          check(outData1 === e1, "R11 RGGB phase", outData1, e1);
        end else begin
          check(outValid === 1'b0, "R2 even line silent", 32'(outValid), 32'd0);
        end
      end
      if (gap) begin
        pixValid = 1'b0; pixData = 10'h3FF;
        @(negedge clk);
      end
    end
    pixValid = 1'b0; lineValid = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic sendFrame(int seed, int lines, bit gap);
    frameValid = 1'b1; @(negedge clk);
    for (int ln = 0; ln < lines; ln++) sendLine(seed, ln, gap);
    frameValid = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  task automatic testReset();
    check(outValid === 1'b0, "R1 valid in reset", 32'(outValid), 0);
    rstN = 1'b1; @(negedge clk);
    check(outValid === 1'b0 && outData === 32'h0, "R1 after reset", outData, 0);
  endtask

  task automatic testBackpressure();
    logic [31:0] q0, q2, q3;
    q0 = quadWord(0, 5, 1, 0); q2 = quadWord(0, 5, 1, 2); q3 = quadWord(0, 5, 1, 3);
    frameValid = 1'b1; @(negedge clk);
    sendLine(5, 0, 0);
    outReady = 1'b0; lineValid = 1'b1;
    drivePix(pv(5, 1, 0)); drivePix(pv(5, 1, 1));
    check(outValid === 1'b1 && outData === q0, "R8 first word held", outData, q0);
    drivePix(pv(5, 1, 2)); drivePix(pv(5, 1, 3));
    check(outValid === 1'b1 && outData === q0, "R9 quad1 dropped", outData, q0);
    drivePix(pv(5, 1, 4));
    check(outData === q0, "R8 still stable", outData, q0);
    outReady = 1'b1;
    drivePix(pv(5, 1, 5));
    check(outValid === 1'b1 && outData === q2, "R10 same-cycle swap", outData, q2);
    drivePix(pv(5, 1, 6)); drivePix(pv(5, 1, 7));
    check(outValid === 1'b1 && outData === q3, "R10 next word", outData, q3);
    pixValid = 1'b0; lineValid = 1'b0; @(negedge clk);
    check(outValid === 1'b0, "R8 drained", 32'(outValid), 0);
    frameValid = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  task automatic testParity();
    frameValid = 1'b1; @(negedge clk);
    sendLine(7, 0, 0);
    frameValid = 1'b0; @(negedge clk); @(negedge clk);
    sendFrame(8, 2, 0);  // R7: new frame's line 0 must stay silent
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    sendFrame(3, 4, 0);   // R2 R3 R5 R11
    sendFrame(99, 2, 0);  // R4 max greens
    sendFrame(98, 2, 0);  // R4 truncation
    sendFrame(11, 2, 1);  // R6 gaps
    testParity();         // R7
    testBackpressure();   // R8 R9 R10
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule